// File: doc/BRIEF.md
# Lane Built-In Test Checker

This block checks, one lane at a time, the 16-bit words that arrive after demapping against a sequence it generates itself. Software sets it up through a small register port. It chooses between normal and test operation, and it selects one of two pseudo-random polynomials with a starting seed, or a fixed user pattern to expect on every word. The framing logic marks each test burst with a one-cycle start pulse and a one-cycle end pulse. Between those pulses the checker compares every valid word with the expected word.

For each burst the checker keeps four results. It counts words in error. It counts symbol slots in error, where each word covers seven symbols on the lane. It records the position within the burst of the first bad word. When the burst ends it gives a pass or fail verdict. Software reads all of these through the same register port. Counters saturate instead of wrapping, so a long bad burst still reads as "many errors".

Top module: `lbt_checker`

## Requirements
- R1: After synchronous reset, every register reads 0: control, seed, pattern, status, both error counts and the first-error index.
- R2: Register addresses are: 0 control (bit0 test enable, bit1 polynomial where 0 is PRBS9 and 1 is PRBS15, bit2 pattern mode, bit3 write-only clear), 1 seed (15 bits), 2 pattern (16 bits), 3 status, 4 word errors, 5 symbol errors, 6 first-error index. Writes take effect at the next clock edge. Reads are combinational and zero-extended.
- R3: While test enable is 0, burst pulses and words are ignored: the status and the counts keep their values.
- R4: A burst-start pulse in test mode reloads the generator from the seed, clears both counts, the first-error index and the verdict, and sets status bit0 (active). A seed that is zero in the active width loads all ones instead.
- R5: PRBS9 (x^9+x^5+1): each generated bit is state[8]^state[4]. That bit is shifted into state bit0. Sixteen bits per word, with the first bit in word bit 15.
- R6: PRBS15 (x^15+x^14+1): each generated bit is state[14]^state[13], shifted in the same way. Word bit 15 is again the first bit.
- R7: In pattern mode, the expected value of every word is the pattern register.
- R8: The word error count increases by one for each accepted word that differs from the expected word.
- R9: The symbol error count increases by the number of erroneous slots in a word. The difference is split into seven slots: bits 2:0, 4:3, 6:5, 8:7, 10:9, 12:11 and 15:13. A slot is erroneous if any of its bits differ.
- R10: The first-error index is the 0-based position of the first erroneous word in the burst. Status bit4 marks it valid. Once valid, the index holds until the next burst start or a clear.
- R11: Both error counts saturate at 0xFFFF.
- R12: A burst-end pulse while active clears bit0 and sets bit1 (done). It also sets bit2 (pass) if the burst had no word errors, and bit3 (fail) otherwise.
- R13: Writing control with bit3 set clears both counts, the first-error index and status bit4. The other control bits are written as usual.
- R14: Words that arrive outside a burst (no start since the last end) are not compared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| word_valid | input | 1 | Received word present this cycle |
| word_data | input | 16 | Received word |
| burst_start | input | 1 | One-cycle pulse opening a burst |
| burst_end | input | 1 | One-cycle pulse closing a burst |

## Verification
If the generator state is wrong, the damage is not limited to one word. Every later word in the burst miscompares, so the word count rises on every word from the first one read after the fault, and the verdict flips to fail at the end pulse. A wrong slot split shows up at once in the symbol count for single-bit and slot-boundary differences, while the word count stays correct. A first-error index that is not held shows up as a larger index as soon as a second bad word arrives. A saturation fault shows only after 65,535 bad words, when the count reads as a small number.

// File: rtl/lbt_pkg.sv
package lbt_pkg;
    localparam int WORD_W = 16;
    localparam int SLOTS  = 7;
    localparam int CNT_W  = 16;
    localparam int LFSR_W = 15;
    localparam int P9_W   = 9;
    localparam int ADDR_W = 3;
    localparam int HIT_W  = $clog2(SLOTS + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef enum logic [ADDR_W-1:0] {
        ADR_CTRL  = 3'd0,
        ADR_SEED  = 3'd1,
        ADR_PAT   = 3'd2,
        ADR_STAT  = 3'd3,
        ADR_WERR  = 3'd4,
        ADR_SERR  = 3'd5,
        ADR_FIRST = 3'd6
    } reg_addr_e;

    typedef enum logic {
        POLY_P9  = 1'b0,
        POLY_P15 = 1'b1
    } poly_e;

    typedef struct packed {
        logic  use_pat;
        poly_e poly;
        logic  test_en;
    } ctrl_t;

    typedef struct packed {
        logic first_vld;
        logic fail;
        logic pass;
        logic done;
        logic active;
    } status_t;

    typedef struct packed {
        logic [LFSR_W-1:0] state;
        logic [WORD_W-1:0] word;
    } prbs_out_t;

    function automatic logic fb_bit(logic [LFSR_W-1:0] s, poly_e p);
        return (p == POLY_P15) ? (s[14] ^ s[13]) : (s[8] ^ s[4]);
    endfunction

    function automatic prbs_out_t prbs_adv(logic [LFSR_W-1:0] s, poly_e p);
        prbs_out_t r;
        logic b;
        r.state = s;
        r.word  = '0;
        for (int i = WORD_W - 1; i >= 0; i--) begin
            b         = fb_bit(r.state, p);
            r.word[i] = b;
            if (p == POLY_P15)
                r.state = {r.state[LFSR_W-2:0], b};
            else
                r.state = {{(LFSR_W-P9_W){1'b0}}, r.state[P9_W-2:0], b};
        end
        return r;
    endfunction

    function automatic logic [LFSR_W-1:0] seed_fix(logic [LFSR_W-1:0] sd, poly_e p);
        if (p == POLY_P15)
            return (sd == '0) ? '1 : sd;
        return (sd[P9_W-1:0] == '0) ? {{(LFSR_W-P9_W){1'b0}}, {P9_W{1'b1}}}
                                    : {{(LFSR_W-P9_W){1'b0}}, sd[P9_W-1:0]};
    endfunction

    function automatic logic [HIT_W-1:0] slot_hits(logic [WORD_W-1:0] d);
        logic [SLOTS-1:0] h;
        h[0] = |d[2:0];
        for (int k = 1; k < SLOTS - 1; k++)
            h[k] = d[2*k+1] | d[2*k+2];
        h[SLOTS-1] = |d[WORD_W-1:13];
        return HIT_W'($countones(h));
    endfunction
endpackage

// File: rtl/lbt_regs.sv
module lbt_regs
    import lbt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    input  status_t           stat,
    input  logic [CNT_W-1:0]  werr,
    input  logic [CNT_W-1:0]  serr,
    input  logic [CNT_W-1:0]  first_idx,
    output logic [WORD_W-1:0] rdata,
    output ctrl_t             ctrl,
    output logic [LFSR_W-1:0] seed,
    output logic [WORD_W-1:0] pattern,
    output logic              clr
);
    localparam int CTRL_W = $bits(ctrl_t);
    localparam int STAT_W = $bits(status_t);

    assign clr = we && (addr == ADR_CTRL) && wdata[CTRL_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl    <= '0;
            seed    <= '0;
            pattern <= '0;
        end else if (we) begin
            case (addr)
                ADR_CTRL: ctrl    <= ctrl_t'(wdata[CTRL_W-1:0]);
                ADR_SEED: seed    <= wdata[LFSR_W-1:0];
                ADR_PAT:  pattern <= wdata;
                default:  ;
            endcase
        end
    end

    always_comb begin
        case (addr)
            ADR_CTRL:  rdata = {{(WORD_W-CTRL_W){1'b0}}, ctrl};
            ADR_SEED:  rdata = {{(WORD_W-LFSR_W){1'b0}}, seed};
            ADR_PAT:   rdata = pattern;
            ADR_STAT:  rdata = {{(WORD_W-STAT_W){1'b0}}, stat};
            ADR_WERR:  rdata = werr;
            ADR_SERR:  rdata = serr;
            ADR_FIRST: rdata = first_idx;
            default:   rdata = '0;
        endcase
    end

    assert_seed_write_R2: assert property (@(posedge clk) disable iff (rst)
        we && (addr == ADR_SEED) |=> seed == $past(wdata[LFSR_W-1:0]));
endmodule

// File: rtl/lbt_pattern_gen.sv
module lbt_pattern_gen
    import lbt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  ctrl_t             ctrl,
    input  logic [LFSR_W-1:0] seed,
    input  logic [WORD_W-1:0] pattern,
    input  logic              load,
    input  logic              advance,
    output logic [WORD_W-1:0] exp_word
);
    logic [LFSR_W-1:0] state;
    prbs_out_t         nxt;

    assign nxt      = prbs_adv(state, ctrl.poly);
    assign exp_word = ctrl.use_pat ? pattern : nxt.word;

    always_ff @(posedge clk) begin
        if (rst)
            state <= '1;
        else if (load)
            state <= seed_fix(seed, ctrl.poly);
        else if (advance && !ctrl.use_pat)
            state <= nxt.state;
    end

    assert_seed_nonzero_R4: assert property (@(posedge clk) disable iff (rst)
        load |=> state != '0);
endmodule

// File: rtl/lbt_compare.sv
module lbt_compare
    import lbt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              test_en,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_data,
    input  logic [WORD_W-1:0] exp_word,
    input  logic              burst_start,
    input  logic              burst_end,
    input  logic              clr,
    output logic              load,
    output logic              accept,
    output status_t           stat,
    output logic [CNT_W-1:0]  werr,
    output logic [CNT_W-1:0]  serr,
    output logic [CNT_W-1:0]  first_idx
);
    logic [WORD_W-1:0] diff;
    logic              miss;
    logic [HIT_W-1:0]  hits;
    logic [CNT_W-1:0]  idx;
    logic [CNT_W:0]    ssum;

    logic [CNT_W-1:0]  werr_n, serr_n, first_n, idx_n;
    status_t           stat_n;

    assign load   = burst_start && test_en;
    assign accept = word_valid && test_en && stat.active;
    assign diff   = word_data ^ exp_word;
    assign miss   = |diff;
    assign hits   = slot_hits(diff);
    assign ssum   = {1'b0, serr} + {{(CNT_W+1-HIT_W){1'b0}}, hits};

    always_comb begin
        werr_n  = werr;
        serr_n  = serr;
        first_n = first_idx;
        idx_n   = idx;
        stat_n  = stat;
        if (load) begin
            werr_n  = '0;
            serr_n  = '0;
            first_n = '0;
            idx_n   = '0;
            stat_n  = '0;
            stat_n.active = 1'b1;
        end else begin
            if (accept && miss) begin
                werr_n = (werr == CNT_MAX) ? CNT_MAX : werr + 1'b1;
                serr_n = ssum[CNT_W] ? CNT_MAX : ssum[CNT_W-1:0];
                if (!stat.first_vld) begin
                    first_n          = idx;
                    stat_n.first_vld = 1'b1;
                end
            end
            if (accept && idx != CNT_MAX)
                idx_n = idx + 1'b1;
            if (clr) begin
                werr_n           = '0;
                serr_n           = '0;
                first_n          = '0;
                stat_n.first_vld = 1'b0;
            end
            if (burst_end && test_en && stat.active) begin
                stat_n.active = 1'b0;
                stat_n.done   = 1'b1;
                stat_n.pass   = (werr_n == '0);
                stat_n.fail   = (werr_n != '0);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            werr      <= '0;
            serr      <= '0;
            first_idx <= '0;
            idx       <= '0;
            stat      <= '0;
        end else begin
            werr      <= werr_n;
            serr      <= serr_n;
            first_idx <= first_n;
            idx       <= idx_n;
            stat      <= stat_n;
        end
    end

    assert_word_step_R8: assert property (@(posedge clk) disable iff (rst)
        !load && !clr |=> (werr >= $past(werr)) &&
                          ({1'b0, werr} <= {1'b0, $past(werr)} + 17'd1));
    assert_first_hold_R10: assert property (@(posedge clk) disable iff (rst)
        stat.first_vld && !load && !clr |=> stat.first_vld && $stable(first_idx));
    assert_no_wrap_R11: assert property (@(posedge clk) disable iff (rst)
        (werr == CNT_MAX) && !load && !clr |=> werr == CNT_MAX);
    assert_verdict_R12: assert property (@(posedge clk) disable iff (rst)
        (stat.pass || stat.fail) |-> stat.done && !stat.active && !(stat.pass && stat.fail));
    assert_idle_R3: assert property (@(posedge clk) disable iff (rst)
        !test_en && !clr |=> $stable(werr) && $stable(serr) && $stable(stat));
endmodule

// File: rtl/lbt_checker.sv
module lbt_checker
    import lbt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_data,
    input  logic              burst_start,
    input  logic              burst_end
);
    ctrl_t             ctrl;
    logic [LFSR_W-1:0] seed;
    logic [WORD_W-1:0] pattern;
    logic              clr;
    logic              load;
    logic              accept;
    logic [WORD_W-1:0] exp_word;
    status_t           stat;
    logic [CNT_W-1:0]  werr, serr, first_idx;

    lbt_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .we        (reg_we),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .stat      (stat),
        .werr      (werr),
        .serr      (serr),
        .first_idx (first_idx),
        .rdata     (reg_rdata),
        .ctrl      (ctrl),
        .seed      (seed),
        .pattern   (pattern),
        .clr       (clr)
    );

    lbt_pattern_gen u_gen (
        .clk      (clk),
        .rst      (rst),
        .ctrl     (ctrl),
        .seed     (seed),
        .pattern  (pattern),
        .load     (load),
        .advance  (accept),
        .exp_word (exp_word)
    );

    lbt_compare u_cmp (
        .clk         (clk),
        .rst         (rst),
        .test_en     (ctrl.test_en),
        .word_valid  (word_valid),
        .word_data   (word_data),
        .exp_word    (exp_word),
        .burst_start (burst_start),
        .burst_end   (burst_end),
        .clr         (clr),
        .load        (load),
        .accept      (accept),
        .stat        (stat),
        .werr        (werr),
        .serr        (serr),
        .first_idx   (first_idx)
    );
endmodule

// File: tb/lbt_checker_bench.sv
`timescale 1ns/1ps
module lbt_checker_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic        word_valid = 1'b0;
    logic [15:0] word_data = 16'd0;
    logic        burst_start = 1'b0;
    logic        burst_end = 1'b0;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    lbt_checker u_lbt_checker (
        .clk (clk), .rst (rst),
        .reg_we (reg_we), .reg_addr (reg_addr), .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
        .word_valid (word_valid), .word_data (word_data),
        .burst_start (burst_start), .burst_end (burst_end)
    );

    localparam logic [2:0] A_CTRL = 3'd0, A_SEED = 3'd1, A_PAT = 3'd2, A_STAT = 3'd3,
                           A_WERR = 3'd4, A_SERR = 3'd5, A_FIRST = 3'd6;
    localparam logic [15:0] PAT = 16'h5A3C;

    // {difference, expected erroneous slots}
    localparam logic [19:0] VEC [0:9] = '{
        {16'h0000, 4'd0}, {16'h0001, 4'd1}, {16'h0007, 4'd1}, {16'h0008, 4'd1},
        {16'h0018, 4'd1}, {16'h2000, 4'd1}, {16'hFFFF, 4'd7}, {16'h8001, 4'd2},
        {16'h0108, 4'd2}, {16'h0155, 4'd4}
    };

    function automatic logic [30:0] model_step(input logic [14:0] s, input logic p15);
        logic [14:0] st;
        logic [15:0] w;
        logic nb;
        st = s;
        w  = '0;
        for (int i = 0; i < 16; i++) begin
            nb = p15 ? (st[14] ^ st[13]) : (st[8] ^ st[4]);
            w  = {w[14:0], nb};
            st = p15 ? {st[13:0], nb} : {6'd0, st[7:0], nb};
        end
        return {st, w};
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input logic [15:0] exp);
        logic [15:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic pulse_start();
        @(negedge clk); burst_start = 1'b1;
        @(negedge clk); burst_start = 1'b0;
    endtask

    task automatic pulse_end();
        @(negedge clk); burst_end = 1'b1;
        @(negedge clk); burst_end = 1'b0;
    endtask

    task automatic send_words(input logic [15:0] w, input int n);
        @(negedge clk); word_valid = 1'b1; word_data = w;
        repeat (n) @(negedge clk);
        word_valid = 1'b0;
    endtask

    // PRBS burst: n words from seed, errors xor'ed in at positions e1/e2 (-1 for none)
    task automatic prbs_burst(input logic [14:0] sd, input logic p15, input int n,
                              input int e1, input logic [15:0] x1,
                              input int e2, input logic [15:0] x2);
        logic [14:0] st;
        logic [30:0] r;
        logic [15:0] w;
        if (p15) st = (sd == 0) ? 15'h7FFF : sd;
        else     st = (sd[8:0] == 0) ? 15'h01FF : {6'd0, sd[8:0]};
        pulse_start();
        for (int i = 0; i < n; i++) begin
            r  = model_step(st, p15);
            st = r[30:16];
            w  = r[15:0];
            if (i == e1) w = w ^ x1;
            if (i == e2) w = w ^ x2;
            @(negedge clk); word_valid = 1'b1; word_data = w;
        end
        @(negedge clk); word_valid = 1'b0;
        pulse_end();
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd_chk("R1 ctrl", A_CTRL, 16'h0);
        rd_chk("R1 seed", A_SEED, 16'h0);
        rd_chk("R1 pattern", A_PAT, 16'h0);
        rd_chk("R1 status", A_STAT, 16'h0);
        rd_chk("R1 werr", A_WERR, 16'h0);
        rd_chk("R1 serr", A_SERR, 16'h0);
        rd_chk("R1 first", A_FIRST, 16'h0);

        // R2 register write/readback
        wr(A_SEED, 16'h1234);
        rd_chk("R2 seed", A_SEED, 16'h1234);
        wr(A_PAT, 16'hBEEF);
        rd_chk("R2 pattern", A_PAT, 16'hBEEF);
        wr(A_CTRL, 16'h0006);
        rd_chk("R2 ctrl", A_CTRL, 16'h0006);

        // R3 normal mode: bursts and words ignored
        wr(A_CTRL, 16'h0000);
        pulse_start();
        rd_chk("R3 status after start", A_STAT, 16'h0);
        send_words(16'hFFFF, 4);
        pulse_end();
        rd_chk("R3 status", A_STAT, 16'h0);
        rd_chk("R3 werr", A_WERR, 16'h0);
        rd_chk("R3 serr", A_SERR, 16'h0);

        // R5 PRBS9, R4 active flag
        wr(A_CTRL, 16'h0001);
        wr(A_SEED, 16'h00A5);
        pulse_start();
        rd_chk("R4 active", A_STAT, 16'h0001);
        rd_chk("R4 werr cleared", A_WERR, 16'h0);
        pulse_end();
        prbs_burst(15'h00A5, 1'b0, 20, -1, 16'h0, -1, 16'h0);
        rd_chk("R5 prbs9 werr", A_WERR, 16'h0);
        rd_chk("R12 prbs9 pass", A_STAT, 16'h0006);

        // R4 zero seed -> all ones (PRBS9)
        wr(A_SEED, 16'h0000);
        prbs_burst(15'h0000, 1'b0, 10, -1, 16'h0, -1, 16'h0);
        rd_chk("R4 zero seed p9 werr", A_WERR, 16'h0);

        // R6 PRBS15, R4 zero seed
        wr(A_CTRL, 16'h0003);
        prbs_burst(15'h0000, 1'b1, 12, -1, 16'h0, -1, 16'h0);
        rd_chk("R4 zero seed p15 werr", A_WERR, 16'h0);
        wr(A_SEED, 16'h4321);
        prbs_burst(15'h4321, 1'b1, 30, -1, 16'h0, -1, 16'h0);
        rd_chk("R6 prbs15 werr", A_WERR, 16'h0);
        rd_chk("R6 prbs15 status", A_STAT, 16'h0006);

        // R8 R9 R10 R12 errors at words 5 and 9
        prbs_burst(15'h4321, 1'b1, 30, 5, 16'h0100, 9, 16'h0003);
        rd_chk("R8 werr", A_WERR, 16'd2);
        rd_chk("R9 serr", A_SERR, 16'd2);
        rd_chk("R10 first", A_FIRST, 16'd5);
        rd_chk("R12 fail status", A_STAT, 16'h001A);

        // R14 word outside burst ignored
        send_words(16'h0F0F, 3);
        rd_chk("R14 werr", A_WERR, 16'd2);
        rd_chk("R14 serr", A_SERR, 16'd2);

        // R13 clear
        wr(A_CTRL, 16'h000B);
        rd_chk("R13 werr", A_WERR, 16'h0);
        rd_chk("R13 serr", A_SERR, 16'h0);
        rd_chk("R13 first", A_FIRST, 16'h0);
        rd_chk("R13 status", A_STAT, 16'h000A);
        rd_chk("R13 ctrl", A_CTRL, 16'h0003);

        // R7 R9 pattern mode, vector table
        wr(A_CTRL, 16'h0005);
        wr(A_PAT, PAT);
        for (int v = 0; v < 10; v++) begin
            pulse_start();
            send_words(PAT ^ VEC[v][19:4], 1);
            pulse_end();
            rd_chk($sformatf("R9 serr vec%0d", v), A_SERR, {12'd0, VEC[v][3:0]});
            rd_chk($sformatf("R7 werr vec%0d", v), A_WERR, (VEC[v][19:4] != 0) ? 16'd1 : 16'd0);
            rd_chk($sformatf("R12 status vec%0d", v), A_STAT,
                   (VEC[v][19:4] != 0) ? 16'h001A : 16'h0006);
        end

        // R4 start clears a failed burst
        pulse_start();
        rd_chk("R4 restart status", A_STAT, 16'h0001);
        rd_chk("R4 restart serr", A_SERR, 16'h0);
        pulse_end();
        rd_chk("R12 empty burst pass", A_STAT, 16'h0006);

        // R10 first error held across later errors
        pulse_start();
        send_words(PAT, 2);
        send_words(~PAT, 1);
        send_words(PAT, 1);
        send_words(PAT ^ 16'h0001, 1);
        pulse_end();
        rd_chk("R10 first held", A_FIRST, 16'd2);
        rd_chk("R8 werr two", A_WERR, 16'd2);
        rd_chk("R9 serr eight", A_SERR, 16'd8);

        // R11 saturation
        pulse_start();
        send_words(~PAT, 65540);
        pulse_end();
        rd_chk("R11 werr sat", A_WERR, 16'hFFFF);
        rd_chk("R11 serr sat", A_SERR, 16'hFFFF);
        rd_chk("R10 first sat", A_FIRST, 16'd0);

        summary();
        $finish;
    end
endmodule